// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O port for up to 31 pins, attached to a plain 32-bit register bus with a one-cycle write strobe and a combinational read path. Software programs a driver-enable register and an output latch. The latch is never written directly: one offset raises the chosen bits and another lowers them, so independent agents can change their own pins without a read-modify-write. Every input passes through a two-flop synchronizer, and the synchronized levels can be read back at any time.

Each pin can also act as an interrupt source. A type bit chooses edge or level detection, and one polarity bit chooses rising/falling or high/low. An edge event is latched in a pending bit that software clears by writing 1. A level source shows its live state instead. Two separate per-pin gates, enable and mask, must both be set before a pending source reaches the single registered interrupt line. Capturing both edges is done in software, which flips the polarity bit after each event.

Top module: `gpio_irq_port`

## Requirements
- R1: Byte offsets decode as 0x00 driver enable, 0x04 input levels, 0x0C raise latch bits, 0x10 lower latch bits, 0x14 interrupt enable, 0x18 detection type, 0x1C polarity, 0x20 pending, 0x24 mask; only one register is written per strobe.
- R2: With OE_INVERT=0, a 1 in the driver-enable register sets that pin's `pinOe` high; with OE_INVERT=1, a 1 makes the pin an input (`pinOe` low).
- R3: Writing to offset 0x0C sets each latch bit written as 1 and leaves bits written as 0 unchanged; `pinOut` shows the latch the cycle after the write.
- R4: Writing to offset 0x10 clears each latch bit written as 1 and leaves the others; reading either 0x0C or 0x10 returns the current latch.
- R5: Offset 0x04 returns the synchronized pin levels two clock edges after a pin changes, whatever the driver-enable setting.
- R6: Bits at positions PIN_COUNT and above read as 0 and ignore writes in every register.
- R7: `irqOut` is high only when some pin has pending, enable and mask all 1; it is registered, one cycle after that condition.
- R8: With type bit 1 (level), the pending bit reads 1 while the synchronized input equals the polarity bit (1 = high, 0 = low); it does not latch, and writing to 0x20 does not change it.
- R9: With type bit 0 (edge) and the enable bit set, the pending bit is set on a rising edge when polarity is 1 and on a falling edge when polarity is 0, one edge after the synchronized level changes; it stays set until 1 is written to that bit at 0x20. Edges on a pin whose enable bit is 0 are not captured.
- R10: After reset every register, the latch, pending bits and `irqOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for one cycle |
| regAddr | input | 6 | Byte offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| pinIn | input | PIN_COUNT | Asynchronous pin levels |
| pinOut | output | PIN_COUNT | Output latch to the pad drivers |
| pinOe | output | PIN_COUNT | Active-high driver enable to the pads |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench builds two copies with PIN_COUNT=8, so that bits 8 to 31 of every register can be written and shown to stay zero. One copy uses OE_INVERT=0 and the other OE_INVERT=1. They share the bus and pins, so a single driver-enable write shows both output-enable senses side by side. Edge and level detection, both polarities, the two gates and the exact synchronizer and interrupt latency are exercised on pins 0 and 2 of the normal copy.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_AW   = 6;
  localparam int BUS_W    = 32;

  localparam logic [REG_AW-1:0] OFS_OE   = 6'h00;
  localparam logic [REG_AW-1:0] OFS_IN   = 6'h04;
  localparam logic [REG_AW-1:0] OFS_SET  = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_CLR  = 6'h10;
  localparam logic [REG_AW-1:0] OFS_EN   = 6'h14;
  localparam logic [REG_AW-1:0] OFS_TYPE = 6'h18;
  localparam logic [REG_AW-1:0] OFS_POL  = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_PEND = 6'h20;
  localparam logic [REG_AW-1:0] OFS_MASK = 6'h24;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_OE,
    SEL_IN,
    SEL_LATCH,
    SEL_EN,
    SEL_TYPE,
    SEL_POL,
    SEL_PEND,
    SEL_MASK
  } rdSel_e;

  typedef struct packed {
    logic wrOe;
    logic wrSet;
    logic wrClr;
    logic wrEn;
    logic wrType;
    logic wrPol;
    logic wrPendClr;
    logic wrMask;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output wrStrobe_t         strobes,
  output rdSel_e            rdSel
);

  always_comb begin
    strobes = '0;
    rdSel   = SEL_NONE;
    case (regAddr)
      OFS_OE:   begin rdSel = SEL_OE;    strobes.wrOe      = regWrEn; end
      OFS_IN:   begin rdSel = SEL_IN;                                 end
      OFS_SET:  begin rdSel = SEL_LATCH; strobes.wrSet     = regWrEn; end
      OFS_CLR:  begin rdSel = SEL_LATCH; strobes.wrClr     = regWrEn; end
      OFS_EN:   begin rdSel = SEL_EN;    strobes.wrEn      = regWrEn; end
      OFS_TYPE: begin rdSel = SEL_TYPE;  strobes.wrType    = regWrEn; end
      OFS_POL:  begin rdSel = SEL_POL;   strobes.wrPol     = regWrEn; end
      OFS_PEND: begin rdSel = SEL_PEND;  strobes.wrPendClr = regWrEn; end
      OFS_MASK: begin rdSel = SEL_MASK;  strobes.wrMask    = regWrEn; end
      default:  begin rdSel = SEL_NONE;                               end
    endcase
  end

  // R1: a bus write reaches at most one register
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R1: no register changes without the write strobe
  a_r1_quiet_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (strobes == '0));

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 24,
  parameter bit OE_INVERT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobe_t            strobes,
  input  rdSel_e               rdSel,
  input  logic [PIN_COUNT-1:0] wrBits,
  input  logic [PIN_COUNT-1:0] pinSync,
  output logic [BUS_W-1:0]     rdData,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);

  localparam int PAD_W = BUS_W - PIN_COUNT;

  logic [PIN_COUNT-1:0] oeReg;
  logic [PIN_COUNT-1:0] outLatch;
  logic [PIN_COUNT-1:0] enReg;
  logic [PIN_COUNT-1:0] typeReg;
  logic [PIN_COUNT-1:0] polReg;
  logic [PIN_COUNT-1:0] maskReg;
  logic [PIN_COUNT-1:0] edgePend;
  logic [PIN_COUNT-1:0] prevSync;
  logic [PIN_COUNT-1:0] pendView;
  logic [PIN_COUNT-1:0] capture;
  logic [PIN_COUNT-1:0] clrBits;
  logic [PIN_COUNT-1:0] rdBits;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeReg   <= '0;
      enReg   <= '0;
      typeReg <= '0;
      polReg  <= '0;
      maskReg <= '0;
    end else begin
      if (strobes.wrOe)   oeReg   <= wrBits;
      if (strobes.wrEn)   enReg   <= wrBits;
      if (strobes.wrType) typeReg <= wrBits;
      if (strobes.wrPol)  polReg  <= wrBits;
      if (strobes.wrMask) maskReg <= wrBits;
    end
  end

  // output latch, changed only through the raise and lower offsets
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLatch <= '0;
    end else if (strobes.wrSet) begin
      outLatch <= outLatch | wrBits;
    end else if (strobes.wrClr) begin
      outLatch <= outLatch & ~wrBits;
    end
  end

  assign pinOut = outLatch;

  if (OE_INVERT) begin : g_oe_inv
    assign pinOe = ~oeReg;
  end else begin : g_oe_dir
    assign pinOe = oeReg;
  end

  // per-pin event detection
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_detect
    logic roseNow;
    logic fellNow;
    logic wantedEdge;
    logic levelMatch;
    assign roseNow    = pinSync[i] & ~prevSync[i];
    assign fellNow    = ~pinSync[i] & prevSync[i];
    assign wantedEdge = polReg[i] ? roseNow : fellNow;
    assign levelMatch = (pinSync[i] == polReg[i]);
    assign capture[i] = wantedEdge & enReg[i] & ~typeReg[i];
    assign pendView[i] = typeReg[i] ? levelMatch : edgePend[i];
  end

  assign clrBits = strobes.wrPendClr ? wrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSync <= '0;
      edgePend <= '0;
      irqOut   <= 1'b0;
    end else begin
      prevSync <= pinSync;
      edgePend <= ((edgePend & ~clrBits) | capture) & ~typeReg;
      irqOut   <= |(pendView & enReg & maskReg);
    end
  end

  // read mux
  always_comb begin
    case (rdSel)
      SEL_OE:    rdBits = oeReg;
      SEL_IN:    rdBits = pinSync;
      SEL_LATCH: rdBits = outLatch;
      SEL_EN:    rdBits = enReg;
      SEL_TYPE:  rdBits = typeReg;
      SEL_POL:   rdBits = polReg;
      SEL_PEND:  rdBits = pendView;
      SEL_MASK:  rdBits = maskReg;
      default:   rdBits = '0;
    endcase
  end

  assign rdData = {{PAD_W{1'b0}}, rdBits};

  // R3: every bit written at the raise offset is high next cycle
  a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrSet |=> ((pinOut & $past(wrBits)) == $past(wrBits)));

  // R4: every bit written at the lower offset is low next cycle
  a_r4_clr_drives_low: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrClr |=> ((pinOut & $past(wrBits)) == '0));

  // R9: an edge pending bit is not lost without a clear write
  a_r9_edge_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.wrPendClr && !strobes.wrType && (typeReg == '0))
      |=> ((edgePend & $past(edgePend)) == $past(edgePend)));

  // R7: no request without a pin that is both enabled and unmasked
  a_r7_gated_request: assert property (@(posedge clk) disable iff (!rstN)
    ((enReg & maskReg) == '0) |=> !irqOut);

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 24,
  parameter bit OE_INVERT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [5:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);

  wrStrobe_t            strobes;
  rdSel_e               rdSel;
  logic [PIN_COUNT-1:0] pinSync;
  logic                 unusedWrHigh;

  assign unusedWrHigh = ^regWrData[BUS_W-1:PIN_COUNT];

  gpio_irq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  gpio_irq_sync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  gpio_irq_datapath #(.PIN_COUNT(PIN_COUNT), .OE_INVERT(OE_INVERT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdSel   (rdSel),
    .wrBits  (regWrData[PIN_COUNT-1:0]),
    .pinSync (pinSync),
    .rdData  (regRdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;

  localparam int PINS = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWrEn = 1'b0;
  logic [5:0]      regAddr = '0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     rdA, rdB;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] outA, outB, oeA, oeB;
  logic            irqA, irqB;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gpio_irq_port #(.PIN_COUNT(PINS), .OE_INVERT(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdA), .pinIn(pinIn),
    .pinOut(outA), .pinOe(oeA), .irqOut(irqA));

  gpio_irq_port #(.PIN_COUNT(PINS), .OE_INVERT(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdB), .pinIn(pinIn),
    .pinOut(outB), .pinOe(oeB), .irqOut(irqB));

  localparam logic [5:0] A_OE = 6'h00, A_IN = 6'h04, A_SET = 6'h0C, A_CLR = 6'h10,
    A_EN = 6'h14, A_TYPE = 6'h18, A_POL = 6'h1C, A_PEND = 6'h20, A_MASK = 6'h24;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = rdA;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    rdChk("R10 oe", A_OE, 0);
    rdChk("R10 in", A_IN, 0);
    rdChk("R10 latch", A_SET, 0);
    rdChk("R10 en", A_EN, 0);
    rdChk("R10 type", A_TYPE, 0);
    rdChk("R10 pol", A_POL, 0);
    rdChk("R10 pend", A_PEND, 0);
    rdChk("R10 mask", A_MASK, 0);
    chk("R10 pinOut", outA, 0);
    chk("R10 irq", irqA, 0);
    chk("R2 reset oe normal", oeA, 8'h00);
    chk("R2 reset oe inverted", oeB, 8'hFF);
  endtask

  task automatic t_oe;
    wr(A_OE, 32'hA5);
    rdChk("R2 oe readback", A_OE, 32'hA5);
    chk("R2 oe normal sense", oeA, 8'hA5);
    chk("R2 oe inverted sense", oeB, 8'h5A);
    rd(A_OE, rdA);
    chk("R1 inverted copy same register", rdB, 32'hA5);
  endtask

  task automatic t_setclr;
    wr(A_SET, 32'h0F);
    chk("R3 raise", outA, 8'h0F);
    wr(A_SET, 32'h30);
    chk("R3 raise keeps others", outA, 8'h3F);
    rdChk("R4 read at raise offset", A_SET, 32'h3F);
    wr(A_CLR, 32'h05);
    chk("R4 lower", outA, 8'h3A);
    rdChk("R4 read at lower offset", A_CLR, 32'h3A);
    wr(A_SET, 32'h0);
    chk("R3 zero write no change", outA, 8'h3A);
    wr(A_CLR, 32'h0);
    chk("R4 zero write no change", outA, 8'h3A);
  endtask

  task automatic t_wide;
    wr(A_OE, 32'hFFFF_FFFF);
    rdChk("R6 oe high bits zero", A_OE, 32'h0000_00FF);
    wr(A_SET, 32'hFFFF_FF00);
    chk("R6 latch unaffected", outA, 8'h3A);
    rdChk("R6 latch read", A_SET, 32'h0000_003A);
    wr(A_MASK, 32'hFFFF_FF00);
    rdChk("R6 mask high bits", A_MASK, 32'h0);
    rdChk("R1 unmapped offset reads zero", 6'h08, 32'h0);
  endtask

  task automatic t_input;
    // driver enable all on: input still visible (R5)
    @(negedge clk); pinIn = 8'h96;
    cyc(1);
    rdChk("R5 one edge not yet", A_IN, 32'h00);
    cyc(1);
    rdChk("R5 two edges visible", A_IN, 32'h96);
    wr(A_OE, 32'h0);
    @(negedge clk); pinIn = 8'h69;
    cyc(2);
    rdChk("R5 input with drivers off", A_IN, 32'h69);
  endtask

  task automatic t_edge;
    wr(A_POL, 32'h01); wr(A_EN, 32'h01); wr(A_MASK, 32'h01);
    @(negedge clk); pinIn = 8'h68;
    cyc(4);
    rdChk("R9 falling ignored in rising mode", A_PEND, 0);
    @(negedge clk); pinIn = 8'h69;
    cyc(2);
    rdChk("R9 not yet pending", A_PEND, 0);
    cyc(1);
    rdChk("R9 rising captured", A_PEND, 32'h01);
    chk("R7 request one cycle later", irqA, 0);
    cyc(1);
    chk("R7 request raised", irqA, 1);
    @(negedge clk); pinIn = 8'h68;
    cyc(4);
    rdChk("R9 sticky after pin drops", A_PEND, 32'h01);
    wr(A_PEND, 32'h0);
    rdChk("R9 zero write keeps pending", A_PEND, 32'h01);
    wr(A_PEND, 32'h01);
    rdChk("R9 write one clears", A_PEND, 0);
    cyc(1);
    chk("R7 request drops after clear", irqA, 0);
    // falling polarity
    wr(A_POL, 32'h0);
    @(negedge clk); pinIn = 8'h69;
    cyc(4);
    rdChk("R9 rising ignored in falling mode", A_PEND, 0);
    @(negedge clk); pinIn = 8'h68;
    cyc(4);
    rdChk("R9 falling captured", A_PEND, 32'h01);
    wr(A_PEND, 32'h01);
    // disabled pin
    wr(A_EN, 32'h0);
    @(negedge clk); pinIn = 8'h69;
    cyc(3);
    @(negedge clk); pinIn = 8'h68;
    cyc(4);
    rdChk("R9 disabled pin not captured", A_PEND, 0);
  endtask

  task automatic t_gate;
    wr(A_POL, 32'h01); wr(A_EN, 32'h01); wr(A_MASK, 32'h0);
    @(negedge clk); pinIn = 8'h69;
    cyc(4);
    rdChk("R7 pending while masked", A_PEND, 32'h01);
    chk("R7 masked no request", irqA, 0);
    wr(A_MASK, 32'h01);
    cyc(1);
    chk("R7 unmasked request", irqA, 1);
    wr(A_EN, 32'h0);
    cyc(1);
    chk("R7 disabled no request", irqA, 0);
    wr(A_EN, 32'h01);
    cyc(1);
    chk("R7 re-enabled request", irqA, 1);
    wr(A_MASK, 32'h0);
    cyc(1);
    chk("R7 mask removes request", irqA, 0);
    wr(A_PEND, 32'h01); wr(A_EN, 32'h0);
  endtask

  task automatic t_level;
    wr(A_TYPE, 32'h04); wr(A_POL, 32'h04); wr(A_EN, 32'h04); wr(A_MASK, 32'h04);
    cyc(1);
    rdChk("R8 low input inactive", A_PEND, 0);
    chk("R8 no request", irqA, 0);
    @(negedge clk); pinIn = 8'h6D;
    cyc(2);
    rdChk("R8 high input active", A_PEND, 32'h04);
    cyc(1);
    chk("R8 level request", irqA, 1);
    wr(A_PEND, 32'h04);
    rdChk("R8 clear write no effect", A_PEND, 32'h04);
    @(negedge clk); pinIn = 8'h69;
    cyc(2);
    rdChk("R8 follows input low", A_PEND, 0);
    cyc(1);
    chk("R8 request follows", irqA, 0);
    wr(A_POL, 32'h0);
    rdChk("R8 active-low polarity", A_PEND, 32'h04);
  endtask

  initial begin
    cyc(5);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_oe();
    t_setclr();
    t_wide();
    t_input();
    t_edge();
    t_gate();
    t_level();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule